// File: doc/BRIEF.md
# EDO DRAM Strobe-Driven Cycle Decoder

This block models the control logic found inside an extended-data-out DRAM with a narrow data word, backed by a small on-chip array. It oversamples the four active-low strobes (row strobe, column strobe, write enable, output enable) on a fast system clock. From the order in which their edges arrive, it works out what kind of cycle the host is running. No command code is involved: the decision comes entirely from edge order.

The multiplexed address bus is read twice in each cycle. The row is taken when the row strobe asserts, and the column is taken at each assertion of the column strobe. Writes store the data present at whichever edge comes later, the column strobe or write enable. Reads load an output hold register. That register keeps driving the data after the column strobe releases, and stops at the next column access, when output enable releases, when write enable asserts, or when both strobes are idle.

Refresh is recognised in two forms: column-before-row and row-only. A column-before-row refresh advances an internal row counter. Holding the column strobe low across a new row strobe pulse gives a hidden refresh, and the read data stays on the pins throughout.

Top module: `edo_dram_ctl`

## Requirements
- R1: After reset the data outputs are not driven, the cycle kind reads 0 (idle) and the refresh row counter reads 0.
- R2: The row is captured when the row strobe asserts. The column is captured when the column strobe asserts. A read returns the word stored at that row and column and reports kind 1 (read).
- R3: If write enable is already asserted in the sample where the column strobe asserts, the cycle is an early write (kind 2). The data sampled at that column edge is stored, and the outputs stay undriven for that column cycle even with output enable asserted.
- R4: If write enable asserts while both strobes are held and the outputs have not driven since the column edge, the cycle is a late write (kind 3). It stores the data sampled at the write-enable edge and leaves the outputs undriven.
- R5: If write enable asserts during a read whose data has already been driven, the cycle is a read-modify-write (kind 4). It stores the data sampled at the write-enable edge.
- R6: The outputs drive only while read data is held, output enable is asserted and write enable is not. Releasing output enable discards the held data, so asserting it again before a new column access drives nothing. Asserting write enable also stops the drive.
- R7: After the column strobe releases, held read data keeps driving with the same value. It stops once both strobes are released.
- R8: A column strobe asserted at least one sample before the row strobe asserts gives a refresh of kind 5. The row counter advances by one modulo 16, nothing is driven, and the array is untouched.
- R9: A row strobe pulse with the column strobe idle throughout reports kind 6 and leaves the refresh counter unchanged.
- R10: With the column strobe held low after a read, the row strobe can release and assert again. The read data stays driven and unchanged, the kind becomes 5, and the counter advances.
- R11: Under one row strobe, several column cycles each capture their own column and are classified on their own as read or early write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Multiplexed row/column address |
| dq_i | input | DW | Write data from the pins |
| dq_o | output | DW | Read data toward the pins |
| dq_oe_o | output | 1 | Pin driver enable |
| cyc_kind_o | output | 3 | Current cycle classification |
| rfsh_row_o | output | AW | Internal refresh row counter |

## Verification
The bench goes after the edge orders that separate the cycle kinds. Write enable arriving in the same sample as the column strobe must give an early write. A design that sampled it one cycle late would instead take a late write, and would briefly drive stale data. A read-modify-write must be told apart from a late write by whether data was already driven; mixing the two up shows as a wrong kind code. Toggling output enable off and on must not bring the data back, and a design that merely gated the drive with output enable would re-drive. Hidden refresh and page-mode hold checks catch a hold register cleared by the wrong strobe edge: the pins go quiet while the column strobe is still low, or after a single strobe releases.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    KIND_IDLE  = 3'd0,
    KIND_READ  = 3'd1,
    KIND_EWR   = 3'd2,
    KIND_LWR   = 3'd3,
    KIND_RMW   = 3'd4,
    KIND_CBR   = 3'd5,
    KIND_RONLY = 3'd6
  } cyc_kind_e;

  localparam int STRB_N   = 4;
  localparam int STRB_RAS = 0;
  localparam int STRB_CAS = 1;
  localparam int STRB_WE  = 2;
  localparam int STRB_OE  = 3;
endpackage

// File: rtl/edo_strobe_sync.sv
module edo_strobe_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic asrt_o,
  output logic asrt_prev_o
);
  logic meta_q, stab_q, prev_q;
  logic meta_d, stab_d, prev_d;

  always_comb begin
    meta_d = strobe_ni;
    stab_d = meta_q;
    prev_d = stab_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= meta_d;
      stab_q <= stab_d;
      prev_q <= prev_d;
    end
  end

  assign asrt_o      = ~stab_q;
  assign asrt_prev_o = ~prev_q;
endmodule

// File: rtl/edo_array.sv
module edo_array #(
  parameter int ABITS = 8,
  parameter int DW    = 4
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [ABITS-1:0] wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [ABITS-1:0] rd_addr_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int DEPTH = 1 << ABITS;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/edo_cycle_ctl.sv
module edo_cycle_ctl import edo_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ras_l_i,
  input  logic            ras_p_i,
  input  logic            cas_l_i,
  input  logic            cas_p_i,
  input  logic            we_l_i,
  input  logic            we_p_i,
  input  logic            oe_l_i,
  input  logic            oe_p_i,
  input  logic [AW-1:0]   addr_s_i,
  input  logic [DW-1:0]   din_s_i,
  input  logic [DW-1:0]   rd_data_i,
  output logic [2*AW-1:0] rd_addr_o,
  output logic            wr_en_o,
  output logic [2*AW-1:0] wr_addr_o,
  output logic [DW-1:0]   wr_data_o,
  output logic [DW-1:0]   dout_o,
  output logic            drive_o,
  output cyc_kind_e       kind_o,
  output logic [AW-1:0]   rfsh_o
);
  localparam logic [AW-1:0] RFSH_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] row_q, row_d;
  logic [AW-1:0] col_q, col_d;
  cyc_kind_e     kind_q, kind_d;
  logic          hold_q, hold_d;
  logic          seen_q, seen_d;
  logic [DW-1:0] dout_q, dout_d;
  logic [AW-1:0] rfsh_q, rfsh_d;

  logic ras_fall, cas_fall, we_fall, oe_rise;
  logic both_idle, col_access, cbr_start, row_start;
  logic early_wr, rd_start, late_wr, drive;
  logic row_en, col_en, dout_en, rfsh_en;

  assign ras_fall  = ras_l_i & ~ras_p_i;
  assign cas_fall  = cas_l_i & ~cas_p_i;
  assign we_fall   = we_l_i & ~we_p_i;
  assign oe_rise   = ~oe_l_i & oe_p_i;
  assign both_idle = ~ras_l_i & ~cas_l_i;

  assign col_access = cas_fall & ras_l_i & ~ras_fall & (kind_q != KIND_CBR);
  assign cbr_start  = ras_fall & cas_l_i & ~cas_fall;
  assign row_start  = ras_fall & ~cas_l_i;
  assign early_wr   = col_access & we_l_i;
  assign rd_start   = col_access & ~we_l_i;
  assign late_wr    = we_fall & ras_l_i & cas_l_i & ~cas_fall & (kind_q == KIND_READ);
  assign drive      = hold_q & oe_l_i & ~we_l_i;

  assign row_en  = row_start;
  assign col_en  = col_access;
  assign dout_en = rd_start;
  assign rfsh_en = cbr_start;

  always_comb begin
    row_d  = row_en  ? addr_s_i : row_q;
    col_d  = col_en  ? addr_s_i : col_q;
    dout_d = dout_en ? rd_data_i : dout_q;
    rfsh_d = rfsh_en ? (rfsh_q + RFSH_ONE) : rfsh_q;

    kind_d = kind_q;
    if (both_idle) begin
      kind_d = KIND_IDLE;
    end else if (cbr_start) begin
      kind_d = KIND_CBR;
    end else if (row_start) begin
      kind_d = KIND_RONLY;
    end else if (early_wr) begin
      kind_d = KIND_EWR;
    end else if (rd_start) begin
      kind_d = KIND_READ;
    end else if (late_wr) begin
      kind_d = seen_q ? KIND_RMW : KIND_LWR;
    end

    hold_d = hold_q;
    if (both_idle) begin
      hold_d = 1'b0;
    end else if (col_access) begin
      hold_d = rd_start;
    end else if (oe_rise || we_fall) begin
      hold_d = 1'b0;
    end

    seen_d = seen_q;
    if (col_access) begin
      seen_d = 1'b0;
    end else if (drive) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q  <= '0;
      col_q  <= '0;
      kind_q <= KIND_IDLE;
      hold_q <= 1'b0;
      seen_q <= 1'b0;
      dout_q <= '0;
      rfsh_q <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      kind_q <= kind_d;
      hold_q <= hold_d;
      seen_q <= seen_d;
      dout_q <= dout_d;
      rfsh_q <= rfsh_d;
    end
  end

  assign rd_addr_o = {row_q, addr_s_i};
  assign wr_en_o   = early_wr | late_wr;
  assign wr_addr_o = early_wr ? {row_q, addr_s_i} : {row_q, col_q};
  assign wr_data_o = din_s_i;
  assign dout_o    = dout_q;
  assign drive_o   = drive;
  assign kind_o    = kind_q;
  assign rfsh_o    = rfsh_q;

  AST_EWR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (kind_q == KIND_EWR) |-> !hold_q); // R3
  AST_LWR_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) ((kind_q == KIND_LWR) && ($past(kind_q) != KIND_LWR)) |-> ($past(kind_q) == KIND_READ)); // R4
  AST_RMW_FROM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni) ((kind_q == KIND_RMW) && ($past(kind_q) != KIND_RMW)) |-> ($past(kind_q) == KIND_READ)); // R5
  AST_HOLD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni) (hold_q && $past(hold_q) && !$past(rd_start)) |-> (dout_q == $past(dout_q))); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni) (!ras_l_i && !cas_l_i) |=> !hold_q); // R7
  AST_RFSH_ONLY_CBR: assert property (@(posedge clk_i) disable iff (!rst_ni) (rfsh_q != $past(rfsh_q)) |-> (kind_q == KIND_CBR)); // R8
endmodule

// File: rtl/edo_dram_ctl.sv
module edo_dram_ctl import edo_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [2:0]    cyc_kind_o,
  output logic [AW-1:0] rfsh_row_o
);
  localparam int ABITS = 2 * AW;

  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  logic [STRB_N-1:0] strb_n, strb_l, strb_p;
  assign strb_n = {oe_ni, we_ni, cas_ni, ras_ni};

  for (genvar gi = 0; gi < STRB_N; gi++) begin : g_sync
    edo_strobe_sync u_sync (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .strobe_ni   (strb_n[gi]),
      .asrt_o      (strb_l[gi]),
      .asrt_prev_o (strb_p[gi])
    );
  end

  logic [AW-1:0] addr_p1_q, addr_p2_q;
  logic [DW-1:0] dq_p1_q, dq_p2_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      addr_p1_q <= '0;
      addr_p2_q <= '0;
      dq_p1_q   <= '0;
      dq_p2_q   <= '0;
    end else begin
      addr_p1_q <= addr_i;
      addr_p2_q <= addr_p1_q;
      dq_p1_q   <= dq_i;
      dq_p2_q   <= dq_p1_q;
    end
  end

  logic [ABITS-1:0] rd_addr, wr_addr;
  logic [DW-1:0]    rd_data, wr_data, dout;
  logic             wr_en, drive;
  cyc_kind_e        kind;
  logic [AW-1:0]    rfsh;

  edo_cycle_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ras_l_i   (strb_l[STRB_RAS]),
    .ras_p_i   (strb_p[STRB_RAS]),
    .cas_l_i   (strb_l[STRB_CAS]),
    .cas_p_i   (strb_p[STRB_CAS]),
    .we_l_i    (strb_l[STRB_WE]),
    .we_p_i    (strb_p[STRB_WE]),
    .oe_l_i    (strb_l[STRB_OE]),
    .oe_p_i    (strb_p[STRB_OE]),
    .addr_s_i  (addr_p2_q),
    .din_s_i   (dq_p2_q),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .dout_o    (dout),
    .drive_o   (drive),
    .kind_o    (kind),
    .rfsh_o    (rfsh)
  );

  edo_array #(.ABITS(ABITS), .DW(DW)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  assign dq_o       = dout;
  assign dq_oe_o    = drive;
  assign cyc_kind_o = kind;
  assign rfsh_row_o = rfsh;

  AST_WR_UNDER_STROBES: assert property (@(posedge clk_i) disable iff (!rst_n) wr_en |-> (strb_l[STRB_RAS] && strb_l[STRB_CAS] && strb_l[STRB_WE])); // R3
endmodule

// File: tb/edo_dram_ctl_tb_top.sv
module edo_dram_ctl_tb_top;
  logic clk, rst_n;
  logic ras_n, cas_n, we_n, oe_n;
  logic [3:0] addr, dq_in, dq_out, rfsh;
  logic dq_oe;
  logic [2:0] kind;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] mem_m [256];
  logic [3:0] rfsh_m;

  edo_dram_ctl #(.AW(4), .DW(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .cyc_kind_o(kind), .rfsh_row_o(rfsh)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [3:0] exp_word(input logic [3:0] r, input logic [3:0] c);
    return mem_m[{r, c}];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic do_read(input logic [3:0] r, input logic [3:0] c, input bit hidden);
    ras_n = 1'b0; addr = r; step();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step();
    chk("R2 read data", 32'(dq_out), 32'(exp_word(r, c)));
    chk("R6 read drive", 32'(dq_oe), 32'd1);
    chk("R2 read kind", 32'(kind), 32'd1);
    if (hidden) begin
      ras_n = 1'b1; step();
      chk("R10 drive after row release", 32'(dq_oe), 32'd1);
      chk("R10 data after row release", 32'(dq_out), 32'(exp_word(r, c)));
      ras_n = 1'b0; step();
      rfsh_m++;
      chk("R10 hidden kind", 32'(kind), 32'd5);
      chk("R10 hidden counter", 32'(rfsh), 32'(rfsh_m));
      chk("R10 hidden drive", 32'(dq_oe), 32'd1);
      chk("R10 hidden data", 32'(dq_out), 32'(exp_word(r, c)));
      ras_n = 1'b1; step();
      cas_n = 1'b1; step();
    end else begin
      cas_n = 1'b1; step();
      chk("R7 hold drive", 32'(dq_oe), 32'd1);
      chk("R7 hold data", 32'(dq_out), 32'(exp_word(r, c)));
      ras_n = 1'b1; step();
    end
    chk("R7 drive ends when idle", 32'(dq_oe), 32'd0);
    chk("R7 kind idle", 32'(kind), 32'd0);
    oe_n = 1'b1;
  endtask

  task automatic do_ewrite(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
    ras_n = 1'b0; addr = r; step();
    we_n = 1'b0; oe_n = 1'b0; dq_in = d; addr = c; cas_n = 1'b0; step();
    mem_m[{r, c}] = d;
    chk("R3 early kind", 32'(kind), 32'd2);
    chk("R3 early no drive", 32'(dq_oe), 32'd0);
    cas_n = 1'b1; we_n = 1'b1; step();
    chk("R3 early no drive after column", 32'(dq_oe), 32'd0);
    ras_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic do_lwrite(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
    oe_n = 1'b1;
    ras_n = 1'b0; addr = r; step();
    addr = c; cas_n = 1'b0; step();
    chk("R4 starts as read", 32'(kind), 32'd1);
    dq_in = d; we_n = 1'b0; step();
    mem_m[{r, c}] = d;
    chk("R4 late kind", 32'(kind), 32'd3);
    chk("R4 late no drive", 32'(dq_oe), 32'd0);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step();
  endtask

  task automatic do_rmw(input logic [3:0] r, input logic [3:0] c, input logic [3:0] d);
    ras_n = 1'b0; addr = r; step();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step();
    chk("R5 read part data", 32'(dq_out), 32'(exp_word(r, c)));
    oe_n = 1'b1; step();
    chk("R6 output enable release", 32'(dq_oe), 32'd0);
    dq_in = d; we_n = 1'b0; step();
    mem_m[{r, c}] = d;
    chk("R5 rmw kind", 32'(kind), 32'd4);
    cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step();
  endtask

  task automatic do_oe_toggle(input logic [3:0] r, input logic [3:0] c);
    ras_n = 1'b0; addr = r; step();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step();
    chk("R6 drive with oe", 32'(dq_oe), 32'd1);
    oe_n = 1'b1; step();
    chk("R6 off at oe release", 32'(dq_oe), 32'd0);
    oe_n = 1'b0; step();
    chk("R6 stays off after oe again", 32'(dq_oe), 32'd0);
    cas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic do_we_hold(input logic [3:0] r, input logic [3:0] c);
    ras_n = 1'b0; addr = r; step();
    addr = c; oe_n = 1'b0; cas_n = 1'b0; step();
    cas_n = 1'b1; step();
    chk("R7 hold before we", 32'(dq_oe), 32'd1);
    we_n = 1'b0; step();
    chk("R6 we stops drive", 32'(dq_oe), 32'd0);
    we_n = 1'b1; step();
    chk("R6 no drive after we release", 32'(dq_oe), 32'd0);
    ras_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic do_cbr();
    oe_n = 1'b0;
    cas_n = 1'b0; step();
    ras_n = 1'b0; step();
    rfsh_m++;
    chk("R8 cbr kind", 32'(kind), 32'd5);
    chk("R8 cbr counter", 32'(rfsh), 32'(rfsh_m));
    chk("R8 cbr no drive", 32'(dq_oe), 32'd0);
    ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; step();
  endtask

  task automatic do_ronly(input logic [3:0] r);
    ras_n = 1'b0; addr = r; step();
    chk("R9 row-only kind", 32'(kind), 32'd6);
    chk("R9 counter unchanged", 32'(rfsh), 32'(rfsh_m));
    chk("R9 no drive", 32'(dq_oe), 32'd0);
    ras_n = 1'b1; step();
    chk("R9 back to idle", 32'(kind), 32'd0);
  endtask

  task automatic do_page(input logic [3:0] r, input int n, input bit fill);
    ras_n = 1'b0; addr = r; step();
    for (int k = 0; k < n; k++) begin
      logic [3:0] c;
      logic [3:0] d;
      bit wr;
      c = fill ? 4'(k) : 4'($urandom());
      d = 4'($urandom());
      wr = fill ? 1'b1 : 1'($urandom_range(0, 1));
      addr = c;
      if (wr) begin
        we_n = 1'b0; oe_n = 1'b1; dq_in = d; cas_n = 1'b0; step();
        mem_m[{r, c}] = d;
        chk("R11 page write kind", 32'(kind), 32'd2);
        chk("R11 page write no drive", 32'(dq_oe), 32'd0);
        cas_n = 1'b1; we_n = 1'b1; step();
      end else begin
        oe_n = 1'b0; cas_n = 1'b0; step();
        chk("R11 page read data", 32'(dq_out), 32'(exp_word(r, c)));
        chk("R11 page read kind", 32'(kind), 32'd1);
        cas_n = 1'b1; step();
        chk("R7 page hold drive", 32'(dq_oe), 32'd1);
        chk("R7 page hold data", 32'(dq_out), 32'(exp_word(r, c)));
      end
    end
    ras_n = 1'b1; oe_n = 1'b1; step();
    chk("R7 page release", 32'(dq_oe), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd917));
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; dq_in = '0; rfsh_m = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    chk("R1 reset drive", 32'(dq_oe), 32'd0);
    chk("R1 reset kind", 32'(kind), 32'd0);
    chk("R1 reset counter", 32'(rfsh), 32'd0);

    for (int r = 0; r < 16; r++) do_page(4'(r), 16, 1'b1);

    do_read(4'd3, 4'd9, 1'b0);
    do_ewrite(4'd3, 4'd9, 4'hA);
    do_read(4'd3, 4'd9, 1'b0);
    do_lwrite(4'd7, 4'd1, 4'h5);
    do_read(4'd7, 4'd1, 1'b1);
    do_rmw(4'd15, 4'd15, 4'hC);
    do_read(4'd15, 4'd15, 1'b0);
    do_oe_toggle(4'd2, 4'd4);
    do_we_hold(4'd8, 4'd0);
    do_ronly(4'd6);
    for (int i = 0; i < 17; i++) do_cbr();
    chk("R8 counter wrapped", 32'(rfsh), 32'(rfsh_m));

    for (int i = 0; i < 250; i++) begin
      logic [3:0] r;
      logic [3:0] c;
      logic [3:0] d;
      r = 4'($urandom()); c = 4'($urandom()); d = 4'($urandom());
      case ($urandom_range(0, 9))
        0: do_read(r, c, 1'b0);
        1: do_read(r, c, 1'b1);
        2: do_ewrite(r, c, d);
        3: do_lwrite(r, c, d);
        4: do_rmw(r, c, d);
        5: do_cbr();
        6: do_ronly(r);
        7: do_page(r, 4, 1'b0);
        8: do_oe_toggle(r, c);
        default: do_we_hold(r, c);
      endcase
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule